// File: doc/BRIEF.md
# Carry-Select Adder with Lookahead Groups

This block is a purely combinational adder of parameterised width (a multiple of four) that produces a sum and a carry-out for two operands plus a carry-in. The same hardware serves unsigned and two's-complement operands, since the sum bits are identical in both readings. When the adder is used on its own, the carry-in is tied to 0.

The operand is cut into 4-bit slices. Inside each slice the carries come from per-bit generate (AND) and propagate (XOR) terms. These carries are flattened into two-level sum-of-products form, so no carry ripples inside a slice. The lowest slice is built once and takes the external carry-in. Every higher slice is built twice, once assuming an incoming carry of 0 and once assuming 1. The real carry leaving the slice below then steers a 2:1 multiplexer that passes on the matching sum nibble and slice carry. The critical path is therefore one lookahead slice followed by a chain of multiplexers.

Top module: `csel_adder`

## Requirements
- R1: For all inputs, {cout, sum} equals the unsigned value a + b + cin, taken to WIDTH+1 bits.
- R2: Read as two's-complement numbers, sum equals a + b + cin modulo 2^WIDTH. For example, -5 + 3 gives -2, and -1 + 1 gives 0 with cout = 1.
- R3: An all-ones operand plus 1 gives sum = 0 and cout = 1. The 1 may come from cin or from the other operand. The carry crosses every slice.
- R4: Raising cin from 0 to 1 with a and b held raises {cout, sum} by exactly one.
- R5: In every duplicated slice, the copy that assumes carry-in 1 gives a 5-bit result {carry, nibble} exactly one greater than the copy that assumes carry-in 0.
- R6: A slice in which every bit propagates (a XOR b all ones) hands its incoming carry unchanged to its outgoing carry. With a = 0xAAAA… and b = 0x5555…, cin = 0 gives all-ones with cout = 0, and cin = 1 gives zero with cout = 1.
- R7: When the most significant bits of a and b are both 1, cout is 1.
- R8: The structure is correct at any width that is a multiple of four. This is shown at 8 bits for every input combination, and at 16 and 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into the least significant bit |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the most significant slice |

## Verification
The in-RTL checks are immediate assertions on combinational values, so they assume every input is a settled 0 or 1 and never X or Z. The bench drives each operand from a fully defined integer before any sample is taken and starts with all inputs at zero. At 8 bits it sweeps every pair of operands with both carry-in values. At 16 and 32 bits it uses random and hand-picked operands, and the hand-picked set covers the all-ones, alternating-bit and top-bit corners.

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NGRP = WIDTH / 4;

  function automatic logic [4:0] cla4(input logic [3:0] x, input logic [3:0] y, input logic ci);
    logic [3:0] p;
    logic [3:0] g;
    logic [4:0] c;
    p = x ^ y;
    g = x & y;
    c[0] = ci;
    c[1] = g[0] | (p[0] & ci);
    c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & ci);
    c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & ci);
    c[4] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0])
         | (p[3] & p[2] & p[1] & p[0] & ci);
    return {c[4], p ^ c[3:0]};
  endfunction

  logic [NGRP:0] gc;
  assign gc[0] = cin;

  genvar k;
  generate
    for (k = 0; k < NGRP; k++) begin : grp
      if (k == 0) begin : base
        logic [4:0] r;
        assign r        = cla4(a[3:0], b[3:0], gc[0]);
        assign sum[3:0] = r[3:0];
        assign gc[1]    = r[4];
      end else begin : dup
        logic [4:0] r0;
        logic [4:0] r1;
        logic [4:0] rs;
        assign r0 = cla4(a[4*k +: 4], b[4*k +: 4], 1'b0);
        assign r1 = cla4(a[4*k +: 4], b[4*k +: 4], 1'b1);
        assign rs = gc[k] ? r1 : r0;
        assign sum[4*k +: 4] = rs[3:0];
        assign gc[k+1]       = rs[4];

        always_comb begin
          assert_copy_step_R5: assert (r1 == r0 + 5'd1)
            else $error("slice %0d copies differ by other than one", k);
          if (&(a[4*k +: 4] ^ b[4*k +: 4])) begin
            assert_slice_pass_R6: assert (gc[k+1] == gc[k])
              else $error("slice %0d did not pass its carry", k);
          end
        end
      end
    end
  endgenerate

  assign cout = gc[NGRP];

  always_comb begin
    if (a[WIDTH-1] && b[WIDTH-1]) begin
      assert_msb_carry_R7: assert (cout)
        else $error("both top bits set but no carry out");
    end
    if (a == '0 && b == '0 && !cin) begin
      assert_zero_sum_R1: assert (sum == '0 && !cout)
        else $error("zero operands gave nonzero result");
    end
  end
endmodule

// File: tb/csel_adder_test.sv
module csel_adder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] a32, b32, s32;
  logic        c32, co32;
  logic [15:0] a16, b16, s16;
  logic        c16, co16;
  logic [7:0]  a8, b8, s8;
  logic        c8, co8;

  csel_adder #(.WIDTH(32)) uut (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));
  csel_adder #(.WIDTH(16)) u16 (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));
  csel_adder #(.WIDTH(8))  u8  (.a(a8),  .b(b8),  .cin(c8),  .sum(s8),  .cout(co8));

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive32(input logic [31:0] x, input logic [31:0] y, input logic ci);
    a32 = x; b32 = y; c32 = ci; #2;
  endtask

  task automatic drive16(input logic [15:0] x, input logic [15:0] y, input logic ci);
    a16 = x; b16 = y; c16 = ci; #2;
  endtask

  initial begin
    a32 = '0; b32 = '0; c32 = 1'b0;
    a16 = '0; b16 = '0; c16 = 1'b0;
    a8  = '0; b8  = '0; c8  = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 zero inputs 32", {co32, s32}, 33'd0);
    check("R1 zero inputs 16", {16'd0, co16, s16}, 33'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        for (int c = 0; c < 2; c++) begin
          a8 = i[7:0]; b8 = j[7:0]; c8 = c[0]; #1;
          check("R8 exhaustive 8-bit", {24'd0, co8, s8}, 33'(i + j + c));
        end

    for (int n = 0; n < 2000; n++) begin
      logic [31:0] x, y;
      logic ci;
      x = $urandom; y = $urandom; ci = $urandom_range(0, 1);
      drive32(x, y, ci);
      check("R1 random 32", {co32, s32}, {1'b0, x} + {1'b0, y} + 33'(ci));
      drive16(x[15:0], y[15:0], ci);
      check("R1 random 16", {16'd0, co16, s16}, 33'({1'b0, x[15:0]} + {1'b0, y[15:0]} + 17'(ci)));
    end

    for (int n = 0; n < 500; n++) begin
      logic [31:0] x, y;
      logic [32:0] r0;
      x = $urandom; y = $urandom;
      drive32(x, y, 1'b0); r0 = {co32, s32};
      drive32(x, y, 1'b1);
      check("R4 cin adds one", {co32, s32}, r0 + 33'd1);
    end

    drive32(-32'sd5, 32'sd3, 1'b0);
    check("R2 -5+3", {1'b0, s32}, {1'b0, 32'hFFFF_FFFE});
    drive32(32'hFFFF_FFFF, 32'd1, 1'b0);
    check("R2 -1+1", {co32, s32}, {1'b1, 32'd0});
    for (int n = 0; n < 300; n++) begin
      int sx, sy;
      sx = $signed($urandom_range(0, 2000)) - 1000;
      sy = $signed($urandom_range(0, 2000)) - 1000;
      drive16(16'(sx), 16'(sy), 1'b0);
      check("R2 signed 16", {17'd0, s16}, {17'd0, 16'(sx + sy)});
    end

    drive32(32'hFFFF_FFFF, 32'd0, 1'b1);
    check("R3 ones+cin 32", {co32, s32}, {1'b1, 32'd0});
    drive32(32'hFFFF_FFFF, 32'd1, 1'b0);
    check("R3 ones+1 32", {co32, s32}, {1'b1, 32'd0});
    drive16(16'hFFFF, 16'd0, 1'b1);
    check("R3 ones+cin 16", {16'd0, co16, s16}, {16'd0, 1'b1, 16'd0});
    drive16(16'hFFFF, 16'd1, 1'b0);
    check("R3 ones+1 16", {16'd0, co16, s16}, {16'd0, 1'b1, 16'd0});

    drive32(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
    check("R6 propagate cin0", {co32, s32}, {1'b0, 32'hFFFF_FFFF});
    drive32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    check("R6 propagate cin1", {co32, s32}, {1'b1, 32'd0});

    drive32(32'h8000_0000, 32'h8000_0000, 1'b0);
    check("R7 top bits", {co32, s32}, {1'b1, 32'd0});
    drive16(16'h8001, 16'hC000, 1'b0);
    check("R7 top bits 16", {16'd0, co16, s16}, {16'd0, 1'b1, 16'h4001});

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule